// File: doc/BRIEF.md
# Transmit Phase-Align Buffer with Error and Self-Test Status

This block moves 10-bit transmit characters (8 data bits, 2 control bits) from a capture clock into the character clock that feeds the serializer. The capture clock is either a dedicated transmit input clock or the reference clock itself. It must run at the same frequency as the reference clock, but its phase relative to it is free. An 8-entry elastic store with Gray-coded pointers absorbs that phase offset. A re-center command places the read pointer four entries behind the write pointer.

A single status output, `txErr`, combines several conditions. It latches on any pointer collision (underflow or overflow) and stays high until a word-sync strobe arrives or a re-center is performed. It is forced high while the transmit PLL is powered down (both output enables low) and while the reference clock has stopped. When self-test mode is active, the latched error is hidden and the output carries a one-cycle pass pulse with a fixed period instead.

Top module: `txpab_top`

## Requirements
- R1: With `clkSelRef`=0 and the input clock at any phase offset against `refClk`, after a re-center the output characters `{charCtrl,charData}` are the input characters in order, one per `refClk` cycle, and `txErr` is 0.
- R2: With `clkSelRef`=1, characters are captured on `refClk`. The dedicated `txClk` may be stopped, data still flows in order and `txErr` stays 0.
- R3: After reset and before the first re-center, `txErr` is 1. Once `recenterN` has been held at 0 and released, `txErr` reads 0.
- R4: A read that finds the buffer empty or passed (input clock stalled) sets `txErr`. It stays set after the pointer spacing has been restored.
- R5: A write into a full buffer (input clock running fast) sets `txErr`. It stays set after the spacing has been restored.
- R6: After a re-center has taken place, a one-cycle `syncSent` strobe clears a latched error in the following cycle, provided no new fault occurs in that cycle.
- R7: Before the first re-center, a `syncSent` strobe is ignored and `txErr` stays 1.
- R8: Holding `recenterN` at 0 clears a latched error and realigns the pointers, after which data flows in order.
- R9: With `bistEnN`=0 and `bistLong`=0, `txErr` pulses high for exactly one `refClk` cycle every 511 cycles.
- R10: With `bistEnN`=0 and `bistLong`=1, the pulse period is 527 cycles.
- R11: `txErr` is 1 whenever `oeA` and `oeB` are both 0. It is 0 when either one is 1 and nothing else is wrong.
- R12: If `refClk` shows no edge for 64 `monClk` cycles, `txErr` goes high. Before that limit is reached it stays low. Once edges return, it drops again.
- R13: While self-test is active, a latched error does not appear on `txErr` between pass pulses. It reappears when self-test is turned off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference/character clock; read side of the buffer |
| txClk | input | 1 | Dedicated transmit input clock |
| monClk | input | 1 | Free-running clock for reference-loss detection |
| rstN | input | 1 | Asynchronous active-low reset |
| clkSelRef | input | 1 | 0: capture on txClk, 1: capture on refClk |
| recenterN | input | 1 | Active-low re-center command |
| syncSent | input | 1 | One-cycle strobe (refClk domain): word sync transmitted |
| bistEnN | input | 1 | Active-low self-test enable |
| bistLong | input | 1 | Pass period select: 1 = 527, 0 = 511 cycles |
| oeA | input | 1 | Output enable A; both low means PLL powered down |
| oeB | input | 1 | Output enable B |
| txData | input | 8 | Character data bits |
| txCtrl | input | 2 | Character control bits |
| charData | output | 8 | Data bits delivered in refClk domain |
| charCtrl | output | 2 | Control bits delivered in refClk domain |
| txErr | output | 1 | Combined error / self-test pass output |

## Verification
The bench uses the default parameters: depth 8, a 64-cycle loss limit, and self-test periods of 511 and 527. At these values every error path and both pass periods are reached in a few thousand cycles. The phase of the input clock is swept across one whole reference period. Controlled stalls and double-rate bursts push the pointer spacing past either limit and then restore it, so the sticky behaviour can be seen apart from the fault itself. Whole self-test windows are counted to measure exact pulse widths and periods.

// File: rtl/txpab_pkg.sv
`timescale 1ns/1ps
package txpab_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic track;       // read pointer follows write pointer at fixed spacing
  } dpCtl_t;

  // datapath -> control fault strobes (refClk domain)
  typedef struct packed {
    logic underflow;
    logic overflow;
  } dpStat_t;
endpackage

// File: rtl/txpab_sync.sv
`timescale 1ns/1ps
module txpab_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/txpab_datapath.sv
`timescale 1ns/1ps
module txpab_datapath
  import txpab_pkg::*;
#(
  parameter int CHAR_W = 10,
  parameter int DEPTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] wrChar,
  input  dpCtl_t            ctl,
  output logic [CHAR_W-1:0] rdChar,
  output dpStat_t           stat
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CENTER = DEPTH / 2;
  // observed spacing = real spacing minus the crossing latency
  localparam int TRACK_OFS = CENTER - SYNC_STAGES - 1;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] toBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [CHAR_W-1:0] mem [DEPTH];

  // ---------------- write side ----------------
  logic [PW-1:0] wrBin, wrGray, rdGraySync, rdSyncBin, wrLevel;
  logic          ovfTgl;
  logic [PW-1:0] rdGray;

  txpab_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_rdPtrSync (
    .clk(wrClk), .rstN(rstN), .d(rdGray), .q(rdGraySync));

  assign rdSyncBin = toBin(rdGraySync);
  assign wrLevel   = wrBin - rdSyncBin;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
      ovfTgl <= 1'b0;
    end else begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= toGray(wrBin + 1'b1);
      if (wrLevel[AW]) ovfTgl <= ~ovfTgl;
    end
  end

  always_ff @(posedge wrClk) mem[wrBin[AW-1:0]] <= wrChar;

  p_wr_advance_r1: assert property (@(posedge wrClk) disable iff (!rstN)
    1'b1 |=> wrBin == PW'($past(wrBin) + 1'b1));

  // ---------------- read side ----------------
  logic [PW-1:0] wrGraySync, wrSyncBin, rdBin, rdNext, rdLevel;
  logic          ovfSync, ovfPrev;

  txpab_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_wrPtrSync (
    .clk(rdClk), .rstN(rstN), .d(wrGray), .q(wrGraySync));
  txpab_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ovfSync (
    .clk(rdClk), .rstN(rstN), .d(ovfTgl), .q(ovfSync));

  assign wrSyncBin = toBin(wrGraySync);
  assign rdLevel   = wrSyncBin - rdBin;
  assign rdNext    = ctl.track ? PW'(wrSyncBin - PW'(TRACK_OFS)) : PW'(rdBin + 1'b1);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin   <= '0;
      rdGray  <= '0;
      ovfPrev <= 1'b0;
      rdChar  <= '0;
    end else begin
      rdBin   <= rdNext;
      rdGray  <= toGray(rdNext);
      ovfPrev <= ovfSync;
      rdChar  <= mem[rdBin[AW-1:0]];
    end
  end

  assign stat.underflow = !ctl.track && ((rdLevel == '0) || rdLevel[AW]);
  assign stat.overflow  = !ctl.track && (ovfSync != ovfPrev);

  p_rd_advance_r1: assert property (@(posedge rdClk) disable iff (!rstN)
    !ctl.track |=> rdBin == PW'($past(rdBin) + 1'b1));
endmodule

// File: rtl/txpab_control.sv
`timescale 1ns/1ps
module txpab_control
  import txpab_pkg::*;
#(
  parameter int PERIOD_SHORT = 511,
  parameter int PERIOD_LONG = 527,
  parameter int LOSS_LIMIT = 64
) (
  input  logic    rdClk,
  input  logic    monClk,
  input  logic    rstN,
  input  logic    recenterN,
  input  logic    syncSent,
  input  logic    bistEnN,
  input  logic    bistLong,
  input  logic    oeA,
  input  logic    oeB,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    txErr
);
  localparam int CNT_W = $clog2(PERIOD_LONG);
  localparam int LW = $clog2(LOSS_LIMIT + 1);

  // ---------------- re-center and sticky error ----------------
  logic recSyncQ, recActive, armed, errSticky, fault;

  txpab_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_recSync (
    .clk(rdClk), .rstN(rstN), .d(recenterN), .q(recSyncQ));

  assign recActive = !recSyncQ;
  assign ctl.track = recActive || !armed;
  assign fault     = stat.underflow || stat.overflow;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      errSticky <= 1'b1;
    end else begin
      if (recActive) armed <= 1'b1;
      if (recActive)                errSticky <= 1'b0;
      else if (fault)               errSticky <= 1'b1;
      else if (syncSent && armed)   errSticky <= 1'b0;
    end
  end

  p_fault_sets_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    fault && !recActive |=> errSticky);
  p_sticky_hold_r5: assert property (@(posedge rdClk) disable iff (!rstN)
    errSticky && !recActive && !(syncSent && armed) |=> errSticky);
  p_sync_clears_r6: assert property (@(posedge rdClk) disable iff (!rstN)
    armed && !recActive && syncSent && !fault |=> !errSticky);
  p_sync_ignored_r7: assert property (@(posedge rdClk) disable iff (!rstN)
    !armed && !recActive && syncSent |=> errSticky);

  // ---------------- self-test pass counter ----------------
  logic [CNT_W-1:0] bistCnt, lastIdx;
  logic             bistOn, bistPulse;

  assign bistOn    = !bistEnN;
  assign lastIdx   = bistLong ? CNT_W'(PERIOD_LONG - 1) : CNT_W'(PERIOD_SHORT - 1);
  assign bistPulse = bistOn && (bistCnt == lastIdx);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)                 bistCnt <= '0;
    else if (!bistOn)          bistCnt <= '0;
    else if (bistCnt == lastIdx) bistCnt <= '0;
    else                       bistCnt <= bistCnt + 1'b1;
  end

  p_bist_single_r9: assert property (@(posedge rdClk) disable iff (!rstN)
    bistPulse |=> !bistPulse);

  // ---------------- reference-loss monitor ----------------
  logic          refSeen, refPrev, refLost;
  logic [LW-1:0] lossCnt;

  txpab_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_refSamp (
    .clk(monClk), .rstN(rstN), .d(rdClk), .q(refSeen));

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      lossCnt <= '0;
    end else begin
      refPrev <= refSeen;
      if (refSeen != refPrev)            lossCnt <= '0;
      else if (lossCnt != LW'(LOSS_LIMIT)) lossCnt <= lossCnt + 1'b1;
    end
  end

  assign refLost = (lossCnt == LW'(LOSS_LIMIT));

  p_edge_restores_r12: assert property (@(posedge monClk) disable iff (!rstN)
    refSeen != refPrev |=> !refLost);

  // ---------------- combined output ----------------
  assign txErr = (!oeA && !oeB) || refLost || (bistOn ? bistPulse : errSticky);
endmodule

// File: rtl/txpab_top.sv
`timescale 1ns/1ps
module txpab_top
  import txpab_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 2,
  parameter int DEPTH = 8,
  parameter int PERIOD_SHORT = 511,
  parameter int PERIOD_LONG = 527,
  parameter int LOSS_LIMIT = 64
) (
  input  logic              refClk,
  input  logic              txClk,
  input  logic              monClk,
  input  logic              rstN,
  input  logic              clkSelRef,
  input  logic              recenterN,
  input  logic              syncSent,
  input  logic              bistEnN,
  input  logic              bistLong,
  input  logic              oeA,
  input  logic              oeB,
  input  logic [DATA_W-1:0] txData,
  input  logic [CTRL_W-1:0] txCtrl,
  output logic [DATA_W-1:0] charData,
  output logic [CTRL_W-1:0] charCtrl,
  output logic              txErr
);
  localparam int CHAR_W = DATA_W + CTRL_W;

  logic              wrClk;
  logic [CHAR_W-1:0] rdChar;
  dpCtl_t            ctl;
  dpStat_t           stat;

  assign wrClk = clkSelRef ? refClk : txClk;

  txpab_datapath #(.CHAR_W(CHAR_W), .DEPTH(DEPTH), .SYNC_STAGES(2)) u_dp (
    .wrClk(wrClk), .rdClk(refClk), .rstN(rstN),
    .wrChar({txCtrl, txData}), .ctl(ctl), .rdChar(rdChar), .stat(stat));

  txpab_control #(.PERIOD_SHORT(PERIOD_SHORT), .PERIOD_LONG(PERIOD_LONG),
                  .LOSS_LIMIT(LOSS_LIMIT)) u_ctl (
    .rdClk(refClk), .monClk(monClk), .rstN(rstN), .recenterN(recenterN),
    .syncSent(syncSent), .bistEnN(bistEnN), .bistLong(bistLong),
    .oeA(oeA), .oeB(oeB), .stat(stat), .ctl(ctl), .txErr(txErr));

  assign charData = rdChar[DATA_W-1:0];
  assign charCtrl = rdChar[CHAR_W-1:DATA_W];
endmodule

// File: tb/txpab_top_bench.sv
`timescale 1ns/1ps
module txpab_top_bench;
  logic refClk = 0, txClk = 0, monClk = 0, rstN = 0;
  logic clkSelRef = 0, recenterN = 1, syncSent = 0, bistEnN = 1, bistLong = 0;
  logic oeA = 1, oeB = 1;
  logic [7:0] txData = 0;
  logic [1:0] txCtrl = 0;
  wire  [7:0] charData;
  wire  [1:0] charCtrl;
  wire        txErr;

  bit  refRun = 1, txRun = 1, txFast = 0;
  real phaseNs = 1.3;
  int  total = 0, bad = 0;
  logic [9:0] pat = 0;

  txpab_top u_txpab_top (
    .refClk(refClk), .txClk(txClk), .monClk(monClk), .rstN(rstN),
    .clkSelRef(clkSelRef), .recenterN(recenterN), .syncSent(syncSent),
    .bistEnN(bistEnN), .bistLong(bistLong), .oeA(oeA), .oeB(oeB),
    .txData(txData), .txCtrl(txCtrl), .charData(charData),
    .charCtrl(charCtrl), .txErr(txErr));

  // 200 MHz reference clock, stoppable (rests low)
  initial forever begin
    #2.5;
    if (refRun) refClk = ~refClk; else refClk = 1'b0;
  end
  initial forever #3.5 monClk = ~monClk;

  task automatic pulseTx(input bit dbl);
    #(phaseNs); txClk = 1; #1.2; txClk = 0;
    if (dbl) begin #1.3; txClk = 1; #1.2; txClk = 0; end
  endtask

  initial forever begin
    @(posedge refClk);
    if (txRun) fork pulseTx(txFast); join_none
  end

  wire wrSel = clkSelRef ? refClk : txClk;
  initial forever begin
    @(posedge wrSel);
    #0.4;
    pat = pat + 1'b1;
    txData = pat[7:0];
    txCtrl = pat[9:8];
  end

  task automatic step(input int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic recenter();
    recenterN = 0; step(6); recenterN = 1; step(12);
  endtask

  task automatic dataWindow(input string req, input int n);
    logic [9:0] prev, cur;
    int mism = 0;
    step(1);
    prev = {charCtrl, charData};
    repeat (n) begin
      step(1);
      cur = {charCtrl, charData};
      if (cur != prev + 10'd1 || txErr) mism++;
      prev = cur;
    end
    chk(req, mism, 0);
  endtask

  task automatic bistWindow(input int n, output int highs, output int gap, output int wide);
    int lastHi = -1;
    bit prevHi = 0;
    highs = 0; gap = 0; wide = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (txErr) begin
        highs++;
        if (prevHi) wide++;
        if (lastHi >= 0) gap = i - lastHi;
        lastHi = i;
      end
      prevHi = txErr;
    end
  endtask

  task automatic finish();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #150000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    int highs, gap, wide;
    real phases[5] = '{0.3, 1.3, 3.3, 4.3, 2.3};
    #23 rstN = 1;
    step(5);
    chk("R3 error before init", txErr, 1);

    syncSent = 1; step(1); syncSent = 0; step(2);
    chk("R7 sync ignored before recenter", txErr, 1);

    recenter();
    chk("R3 error clear after recenter", txErr, 0);
    dataWindow("R1 order phase 1.3", 30);

    foreach (phases[k]) begin
      phaseNs = phases[k];
      step(3);
      recenter();
      chk("R1 no error after phase change", txErr, 0);
      dataWindow("R1 order phase sweep", 30);
    end

    // underflow: stall writer, then restore spacing
    txRun = 0; step(3); txRun = 1; step(8);
    chk("R4 underflow sets error", txErr, 1);
    txFast = 1; step(3); txFast = 0; step(15);
    chk("R4 error sticky after restore", txErr, 1);
    syncSent = 1; step(1);
    chk("R6 sync clears error", txErr, 0);
    syncSent = 0; step(10);
    chk("R6 error stays clear", txErr, 0);

    // overflow: writer fast, then restore
    txFast = 1; step(4); txFast = 0; step(10);
    chk("R5 overflow sets error", txErr, 1);
    txRun = 0; step(4); txRun = 1; step(10);
    chk("R5 error sticky after restore", txErr, 1);
    recenter();
    chk("R8 recenter clears error", txErr, 0);
    dataWindow("R8 order after recenter", 30);

    // output-enable combinations
    oeA = 0; oeB = 0; step(1);
    chk("R11 both enables off", txErr, 1);
    oeA = 1; step(1);
    chk("R11 enable A on", txErr, 0);
    oeA = 0; oeB = 1; step(1);
    chk("R11 enable B on", txErr, 0);
    oeA = 1; step(2);

    // reference loss
    refRun = 0;
    #200;
    chk("R12 below loss limit", txErr, 0);
    #500;
    chk("R12 reference lost", txErr, 1);
    refRun = 1;
    step(20);
    chk("R12 reference restored", txErr, 0);

    // self-test with a latched error underneath
    txRun = 0; step(3); txRun = 1; step(5);
    chk("R13 latched error before self-test", txErr, 1);
    bistLong = 0; bistEnN = 0;
    bistWindow(1100, highs, gap, wide);
    chk("R9 pulse count short", highs, 2);
    chk("R9 period short", gap, 511);
    chk("R9 pulse width", wide, 0);
    chk("R13 latched error hidden", highs, 2);
    bistEnN = 1; step(2);
    bistLong = 1; bistEnN = 0;
    bistWindow(1100, highs, gap, wide);
    chk("R10 pulse count long", highs, 2);
    chk("R10 period long", gap, 527);
    chk("R10 pulse width", wide, 0);
    bistEnN = 1; step(2);
    chk("R13 latched error returns", txErr, 1);
    recenter();
    chk("R8 clear after self-test", txErr, 0);

    // capture on reference clock, dedicated clock stopped
    clkSelRef = 1; txRun = 0; step(3);
    recenter();
    chk("R2 no error on reference capture", txErr, 0);
    dataWindow("R2 order on reference capture", 30);
    step(20);
    chk("R2 still no error", txErr, 0);

    finish();
  end
endmodule